// File: doc/BRIEF.md
# Clock Frequency Shift Handshake Controller

This block coordinates a change of the external clock frequency while the system keeps running. A shift can be requested in three ways: an active-low request pin, a request bit in the block's configuration register, or an active-low stop-clock input. When a request arrives, the block holds the core and waits for the bus to go idle. It then asserts a ready indication on an active-low pin and mirrors it in a status bit of the same register. The clock source may change frequency only while ready is asserted.

When every request has been withdrawn, ready drops at once. The core hold stays in place for a programmable number of settle cycles, counted on the new clock, and then normal operation resumes. The request pin is honoured only when its enable bit is set. The register request bit and the stop-clock input are always honoured. Overlapping requests produce a single shift.

Top module: `dfs_handshake`

## Requirements
- R1: After reset, `rdy_no` is 1, `core_hold_o` is 0 and `cfg_rdata_o` reads 0x0100. The register fields are: bit 0 pin-path enable, bit 1 software request, bit 2 ready status (read-only), bits 15:8 settle count.
- R2: Writing 1 to bit 1 of the register raises `core_hold_o` one cycle after the write edge. With the bus idle, ready is asserted one cycle later.
- R3: Ready is not asserted while `bus_idle_i` is 0. It is asserted on the first clock edge after the request at which `bus_idle_i` is 1.
- R4: With bit 0 set, driving `shift_req_ni` low raises `core_hold_o` after three clock edges and drives `rdy_no` low after four, with the bus idle.
- R5: With bit 0 clear, `shift_req_ni` has no effect: `core_hold_o` stays 0 and `rdy_no` stays 1.
- R6: Driving `stop_req_ni` low starts a shift with the same timing as R4, whatever the value of bit 0.
- R7: Ready is deasserted on the first clock edge at which no request is seen. `core_hold_o` remains 1 during ready and during the settle period.
- R8: The settle period lasts exactly the settle count in cycles. A count of 0 is treated as 1.
- R9: When requests overlap, one shift is performed, and ready stays asserted until every request has been removed.
- R10: Both request pins pass through a two-flop synchronizer before they are used.
- R11: Status bit 2 reads 1 exactly while `rdy_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_req_ni | input | 1 | Frequency shift request pin, active low, asynchronous |
| stop_req_ni | input | 1 | Stop-clock request, active low, asynchronous |
| bus_idle_i | input | 1 | High when no bus cycle is outstanding |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read data including ready status |
| rdy_no | output | 1 | Shift ready pin, active low |
| core_hold_o | output | 1 | Holds the core quiescent during a shift |

## Verification
The pin path and the register path can both be active in the same window. The release of one path can then coincide with the other still being held. The bench provokes this by asserting the pin, waiting for ready, and then setting the register request. It clears the register request first and checks that the ready pin stays low. Only after the pin is released does it expect ready to drop and the settle period to follow.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int REG_W    = 16;
  localparam int CNT_W    = 8;
  localparam int HW_EN_B  = 0;
  localparam int SW_REQ_B = 1;
  localparam int RDY_B    = 2;
  localparam int SETTLE_LSB = 8;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_READY  = 2'd2,
    ST_SETTLE = 2'd3
  } dfs_state_e;
endpackage

// File: rtl/dfs_sync.sv
module dfs_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_ni,
  output logic [W-1:0] q_no
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_ni[i];
        s2_q <= s1_q;
      end
    end
    assign q_no[i] = s2_q;

    p_sync_two_stage_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_no[i] != $past(q_no[i])) |-> (q_no[i] == $past(d_ni[i], 2)));
  end
endmodule

// File: rtl/dfs_cfg.sv
module dfs_cfg
  import dfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rdy_i,
  output logic             hw_en_o,
  output logic             sw_req_o,
  output logic [CNT_W-1:0] settle_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int PAD_W = SETTLE_LSB - RDY_B - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_en_o  <= 1'b0;
      sw_req_o <= 1'b0;
      settle_o <= CNT_W'(1);
    end else if (we_i) begin
      hw_en_o  <= wdata_i[HW_EN_B];
      sw_req_o <= wdata_i[SW_REQ_B];
      settle_o <= wdata_i[SETTLE_LSB +: CNT_W];
    end
  end

  assign rdata_o = {settle_o, {PAD_W{1'b0}}, rdy_i, sw_req_o, hw_en_o};
endmodule

// File: rtl/dfs_fsm.sv
module dfs_fsm
  import dfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             bus_idle_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             hold_o,
  output logic             rdy_o
);
  dfs_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN:    if (req_i) state_d = ST_DRAIN;
      ST_DRAIN:  if (bus_idle_i) state_d = ST_READY;
      ST_READY:  if (!req_i) begin
                   state_d = ST_SETTLE;
                   cnt_d   = (settle_i == '0) ? CNT_W'(1) : settle_i;
                 end
      ST_SETTLE: begin
                   if (cnt_q == CNT_W'(1)) state_d = ST_RUN;
                   else cnt_d = cnt_q - CNT_W'(1);
                 end
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold_o = (state_q != ST_RUN);
  assign rdy_o  = (state_q == ST_READY);

  p_rdy_after_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(bus_idle_i));
  p_rdy_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !req_i) |=> !rdy_o);
  p_settle_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) |-> (cnt_q != '0));
  p_hold_after_rdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> hold_o);
endmodule

// File: rtl/dfs_handshake.sv
module dfs_handshake
  import dfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_req_ni,
  input  logic             stop_req_ni,
  input  logic             bus_idle_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             rdy_no,
  output logic             core_hold_o
);
  logic [1:0]       pins_sync_n;
  logic             hw_en, sw_req, rdy, any_req;
  logic [CNT_W-1:0] settle;

  dfs_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_ni   ({stop_req_ni, shift_req_ni}),
    .q_no   (pins_sync_n)
  );

  dfs_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdy_i    (rdy),
    .hw_en_o  (hw_en),
    .sw_req_o (sw_req),
    .settle_o (settle),
    .rdata_o  (cfg_rdata_o)
  );

  // pin path gated by its enable; stop-clock and register paths always live
  assign any_req = (hw_en & ~pins_sync_n[0]) | ~pins_sync_n[1] | sw_req;

  dfs_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (any_req),
    .bus_idle_i (bus_idle_i),
    .settle_i   (settle),
    .hold_o     (core_hold_o),
    .rdy_o      (rdy)
  );

  assign rdy_no = ~rdy;

  p_rdy_implies_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |-> core_hold_o);
  p_pin_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_en && !sw_req && pins_sync_n[1] && !core_hold_o) |=> !rdy);
  p_status_pin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[RDY_B] == !rdy_no);
endmodule

// File: tb/dfs_handshake_test.sv
module dfs_handshake_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        shift_req_ni = 1'b1;
  logic        stop_req_ni = 1'b1;
  logic        bus_idle_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        rdy_no, core_hold_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  dfs_handshake uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_req_ni(shift_req_ni),
    .stop_req_ni(stop_req_ni), .bus_idle_i(bus_idle_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .rdy_no(rdy_no),
    .core_hold_o(core_hold_o)
  );

  typedef struct packed {
    logic [7:0] settle;
    logic [8:0] hold_cycles;
  } vec_t;
  // hold cycles after release = 1 (ready) + effective settle
  localparam vec_t VECS [0:4] = '{
    '{8'd1,  9'd2}, '{8'd3, 9'd4}, '{8'd0, 9'd2},
    '{8'd7,  9'd8}, '{8'd20, 9'd21}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_we_i = 1'b1;
    cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    step(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(rdy_no == 1'b1, "R1 rdy_no", int'(rdy_no), 1);
    chk(core_hold_o == 1'b0, "R1 hold", int'(core_hold_o), 0);
    chk(cfg_rdata_o == 16'h0100, "R1 rdata", int'(cfg_rdata_o), 32'h100);

    // table walk: software shifts with various settle counts (R2, R7, R8)
    for (int v = 0; v < 5; v++) begin
      wr({VECS[v].settle, 8'h02});
      chk(core_hold_o == 1'b0, "R2 hold before", int'(core_hold_o), 0);
      step(1);
      chk(core_hold_o == 1'b1 && rdy_no == 1'b1, "R2 drain", int'(rdy_no), 1);
      step(1);
      chk(rdy_no == 1'b0, "R2 ready", int'(rdy_no), 0);
      chk(cfg_rdata_o[2] == 1'b1, "R11 status set", int'(cfg_rdata_o[2]), 1);
      wr({VECS[v].settle, 8'h00});
      cnt = 0;
      while (core_hold_o && cnt < 400) begin
        cnt++;
        @(negedge clk_i);
      end
      chk(cnt == int'(VECS[v].hold_cycles), "R8 settle length", cnt, int'(VECS[v].hold_cycles));
      chk(rdy_no == 1'b1 && cfg_rdata_o[2] == 1'b0, "R11 status clear", int'(cfg_rdata_o[2]), 0);
    end

    // R3 ready waits for bus idle
    bus_idle_i = 1'b0;
    wr(16'h0102);
    step(5);
    chk(core_hold_o == 1'b1 && rdy_no == 1'b1, "R3 no ready when busy", int'(rdy_no), 1);
    bus_idle_i = 1'b1;
    step(1);
    chk(rdy_no == 1'b0, "R3 ready after idle", int'(rdy_no), 0);
    wr(16'h0100);
    step(3);

    // R5 pin ignored while disabled
    shift_req_ni = 1'b0;
    step(10);
    chk(core_hold_o == 1'b0, "R5 hold", int'(core_hold_o), 0);
    chk(rdy_no == 1'b1, "R5 rdy", int'(rdy_no), 1);
    shift_req_ni = 1'b1;
    step(3);

    // R4 / R10 pin path with enable
    wr(16'h0101);
    shift_req_ni = 1'b0;
    step(2);
    chk(core_hold_o == 1'b0, "R10 sync delay", int'(core_hold_o), 0);
    step(1);
    chk(core_hold_o == 1'b1 && rdy_no == 1'b1, "R4 drain", int'(core_hold_o), 1);
    step(1);
    chk(rdy_no == 1'b0, "R4 ready", int'(rdy_no), 0);
    shift_req_ni = 1'b1;
    step(2);
    chk(rdy_no == 1'b0, "R7 ready held through sync", int'(rdy_no), 0);
    step(1);
    chk(rdy_no == 1'b1 && core_hold_o == 1'b1, "R7 release", int'(rdy_no), 1);
    step(3);

    // R6 stop-clock with pin path disabled
    wr(16'h0100);
    stop_req_ni = 1'b0;
    step(3);
    chk(core_hold_o == 1'b1 && rdy_no == 1'b1, "R6 drain", int'(core_hold_o), 1);
    step(1);
    chk(rdy_no == 1'b0, "R6 ready", int'(rdy_no), 0);
    stop_req_ni = 1'b1;
    step(3);
    chk(rdy_no == 1'b1, "R6 release", int'(rdy_no), 1);
    step(3);

    // R9 overlapping pin and register requests
    wr(16'h0101);
    shift_req_ni = 1'b0;
    step(4);
    chk(rdy_no == 1'b0, "R9 ready from pin", int'(rdy_no), 0);
    wr(16'h0103);
    step(2);
    chk(rdy_no == 1'b0, "R9 single shift", int'(rdy_no), 0);
    wr(16'h0101);
    step(4);
    chk(rdy_no == 1'b0, "R9 held by pin", int'(rdy_no), 0);
    shift_req_ni = 1'b1;
    step(3);
    chk(rdy_no == 1'b1, "R9 release", int'(rdy_no), 1);
    step(2);
    chk(core_hold_o == 1'b0, "R9 resume", int'(core_hold_o), 0);

    finish_run();
  end
endmodule